// File: doc/BRIEF.md
# SDRAM Single-Word Access Sequencer

This block turns one request for a single data word into the ordered command sequence an SDR SDRAM expects: open the row, issue the column read or write, then close the row. The delays between these commands come from a 2-bit latency code. One code sets four delays together: the row-to-column delay, the read latency, the minimum time a row stays open, and the row-close recovery time. Codes 2 and 3 give the same timing.

The requester presents a row, a column, a direction flag, write data and a region select, and holds valid high. The block accepts the request in a cycle where ready is high. It drives the active-low command strobes, the multiplexed address and the data-output enable. For a read, it returns the sampled word with a one-cycle strobe. Each region has its own latency code, a write-protect bit and an enable bit. A request that a region refuses produces no SDRAM traffic and a one-cycle error pulse.

Top module: `sdr_word_seq`

## Requirements
- R1: During and right after reset, ready is 1, the command is NOP, the data enable is 0, and error and read-valid are 0.
- R2: A request is accepted at a rising edge where req_valid and ready are both 1. An accepted, permitted request drives ACTIVE with the row on sd_addr in the next cycle. Ready stays 0 from that cycle until the access completes.
- R3: With latency code 0, READ/WRITE comes 1 cycle after ACTIVE, read data is sampled 1 cycle after READ, PRECHARGE comes no sooner than 2 cycles after ACTIVE, and the next ACTIVE comes no sooner than 1 cycle after PRECHARGE.
- R4: With latency code 1, those four delays are 2, 2, 4 and 2 cycles.
- R5: With latency code 2 or code 3, those four delays are 3, 3, 6 and 3 cycles; code 3 is identical to code 2.
- R6: A write drives WRITE with the column on sd_addr, the request's data on sd_dq_out, and sd_dq_oe high in that one cycle only. PRECHARGE follows at the later of (WRITE + 1) and the minimum row-open time.
- R7: A read samples sd_dq_in at the end of the cycle that lies the read latency after READ. rd_valid is then 1 for one cycle with that word on rd_data. PRECHARGE is issued in that same cycle, unless the row-open minimum is later.
- R8: Ready returns early enough that a request presented at once gets its ACTIVE exactly the recovery delay after PRECHARGE.
- R9: Region r takes its latency code from cfg_lat[2r+1:2r], independently of the other region.
- R10: A write to a region whose cfg_wp bit is 1 issues no command, pulses err for one cycle and leaves ready at 1. Reads to that region proceed normally.
- R11: Any request to a region whose cfg_valid bit is 0 issues no command, pulses err for one cycle and leaves ready at 1.
- R12: Commands are encoded on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n] as ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010 and NOP=0111. sd_addr is 0 on every command other than ACTIVE, READ and WRITE.
- R13: While ready is 0, req_valid and the request fields have no effect on the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | SEL_W | Region select |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write word |
| cfg_lat | input | 2*REGIONS | Latency code per region, 2 bits each |
| cfg_wp | input | REGIONS | Write-protect bit per region |
| cfg_valid | input | REGIONS | Enable bit per region |
| ready | output | 1 | Request can be accepted this cycle |
| err | output | 1 | One-cycle pulse on a refused request |
| rd_valid | output | 1 | rd_data holds a read word |
| rd_data | output | DATA_W | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| sd_dq_out | output | DATA_W | Write data to the pads |
| sd_dq_oe | output | 1 | Write data drive enable |
| sd_dq_in | input | DATA_W | Read data from the pads |

## Verification
The bound checker tests the following on every cycle:
- the command code is always one of the five legal values;
- READ/WRITE lands exactly the row-to-column delay after ACTIVE;
- PRECHARGE respects the row-open minimum and ACTIVE respects the recovery time;
- the data enable appears only with WRITE;
- every permitted request leads to ACTIVE and every refused one to an error with NOP.

Three properties need the bench's reference model and chosen stimulus:
- that the read word comes from the right sampling cycle;
- that ready rises in exactly the right cycle for back-to-back accesses;
- that requests held during a busy access leave no trace, and that code 3 produces the same cycle counts as code 2.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
package sdr_seq_pkg;

   // Command codes on {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_ACT = 4'b0011;
   localparam logic [3:0] CMD_RD  = 4'b0101;
   localparam logic [3:0] CMD_WR  = 4'b0100;
   localparam logic [3:0] CMD_PRE = 4'b0010;
   localparam logic [3:0] CMD_NOP = 4'b0111;

   // Gap from last data word to row close, same for every code
   localparam int WR_TO_PRE = 1;
   localparam int RD_TO_PRE = 1;

   localparam int DLY_W = 4;

   typedef struct packed {
      logic [DLY_W-1:0] rcd;   // open row to column command
      logic [DLY_W-1:0] cl;    // read command to data
      logic [DLY_W-1:0] ras;   // minimum open row time
      logic [DLY_W-1:0] rp;    // close to next open
   } dly_t;

   function automatic dly_t lat_delays(input logic [1:0] code);
      dly_t d;
      case (code)
         2'd0:    d = '{rcd: 4'd1, cl: 4'd1, ras: 4'd2, rp: 4'd1};
         2'd1:    d = '{rcd: 4'd2, cl: 4'd2, ras: 4'd4, rp: 4'd2};
         default: d = '{rcd: 4'd3, cl: 4'd3, ras: 4'd6, rp: 4'd3};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/sdr_region_gate.sv
`timescale 1ns/1ps
module sdr_region_gate #(
   parameter int REGIONS = 2,
   parameter int SEL_W   = 1
) (
   input  logic [SEL_W-1:0]     sel,
   input  logic                 wr,
   input  logic [2*REGIONS-1:0] lat_flat,
   input  logic [REGIONS-1:0]   wp,
   input  logic [REGIONS-1:0]   valid,
   output logic                 ok,
   output logic [1:0]           code
);
   localparam int SLOTS = 1 << SEL_W;

   logic [SLOTS-1:0][1:0] lat_a;
   logic [SLOTS-1:0]      wp_a;
   logic [SLOTS-1:0]      vld_a;

   if (REGIONS < 1 || REGIONS > SLOTS) begin : g_bad_cfg
      $error("sdr_region_gate: REGIONS does not fit SEL_W");
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g < REGIONS) begin : g_real
         assign lat_a[g] = lat_flat[2*g +: 2];
         assign wp_a[g]  = wp[g];
         assign vld_a[g] = valid[g];
      end else begin : g_pad
         assign lat_a[g] = 2'd0;
         assign wp_a[g]  = 1'b1;
         assign vld_a[g] = 1'b0;
      end
   end

   assign code = lat_a[sel];
   assign ok   = vld_a[sel] & ~(wr & wp_a[sel]);

endmodule

// File: rtl/sdr_sched_calc.sv
`timescale 1ns/1ps
module sdr_sched_calc
   import sdr_seq_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  sdr_seq_pkg::dly_t   dly,
   input  logic                wr,
   output logic [CNT_W-1:0]    t_cmd,
   output logic [CNT_W-1:0]    t_cap,
   output logic [CNT_W-1:0]    t_pre,
   output logic [CNT_W-1:0]    t_rdy
);
   int c_i, cap_i, pre_i;

   always_comb begin
      c_i   = int'(dly.rcd);
      cap_i = c_i + int'(dly.cl);
      pre_i = wr ? (c_i + WR_TO_PRE) : (cap_i + RD_TO_PRE);
      if (pre_i < int'(dly.ras)) pre_i = int'(dly.ras);
      t_cmd = CNT_W'(c_i);
      t_cap = CNT_W'(cap_i);
      t_pre = CNT_W'(pre_i);
      t_rdy = CNT_W'(pre_i + int'(dly.rp) - 1);
   end

endmodule

// File: rtl/sdr_cmd_timer.sv
`timescale 1ns/1ps
module sdr_cmd_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] t_cmd,
   input  logic [CNT_W-1:0] t_cap,
   input  logic [CNT_W-1:0] t_pre,
   input  logic [CNT_W-1:0] t_rdy,
   output logic             busy,
   output logic             hit_cmd,
   output logic             hit_pre,
   output logic             hit_cap,
   output logic             hit_end
);
   logic             busy_q;
   logic [CNT_W-1:0] t_q, cmd_q, cap_q, pre_q, rdy_q;
   logic [CNT_W-1:0] t_nx;

   assign t_nx = t_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         t_q    <= '0;
         cmd_q  <= '0;
         cap_q  <= '0;
         pre_q  <= '0;
         rdy_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         t_q    <= '0;
         cmd_q  <= t_cmd;
         cap_q  <= t_cap;
         pre_q  <= t_pre;
         rdy_q  <= t_rdy;
      end else if (busy_q) begin
         t_q <= t_nx;
         if (t_nx == rdy_q) busy_q <= 1'b0;
      end
   end

   assign busy    = busy_q;
   assign hit_cmd = busy_q && (t_nx == cmd_q);
   assign hit_pre = busy_q && (t_nx == pre_q);
   assign hit_cap = busy_q && (t_q == cap_q);
   assign hit_end = busy_q && (t_nx == rdy_q);

endmodule

// File: rtl/sdr_word_seq.sv
`timescale 1ns/1ps
module sdr_word_seq
   import sdr_seq_pkg::*;
#(
   parameter int ROW_W   = 13,
   parameter int COL_W   = 10,
   parameter int DATA_W  = 16,
   parameter int REGIONS = 2,
   parameter int CNT_W   = 4,
   localparam int SEL_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1,
   localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [SEL_W-1:0]     req_region,
   input  logic [ROW_W-1:0]     req_row,
   input  logic [COL_W-1:0]     req_col,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [2*REGIONS-1:0] cfg_lat,
   input  logic [REGIONS-1:0]   cfg_wp,
   input  logic [REGIONS-1:0]   cfg_valid,
   output logic                 ready,
   output logic                 err,
   output logic                 rd_valid,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 sd_cs_n,
   output logic                 sd_ras_n,
   output logic                 sd_cas_n,
   output logic                 sd_we_n,
   output logic [ADDR_W-1:0]    sd_addr,
   output logic [DATA_W-1:0]    sd_dq_out,
   output logic                 sd_dq_oe,
   input  logic [DATA_W-1:0]    sd_dq_in
);
   if (CNT_W < 4) begin : g_bad_cnt
      $error("sdr_word_seq: CNT_W must hold the longest access (9)");
   end
   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sdr_word_seq: widths must be positive");
   end

   logic             acc_ok;
   logic [1:0]       acc_code;
   dly_t             acc_dly;
   logic [CNT_W-1:0] s_cmd, s_cap, s_pre, s_rdy;
   logic             busy, hit_cmd, hit_pre, hit_cap, hit_end;
   logic             accept, start;

   logic [3:0]        cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic              oe_q, ready_q, err_q, rv_q;
   logic [DATA_W-1:0] dq_q, rd_q, wd_q;
   logic [COL_W-1:0]  col_q;
   logic              wr_q;

   sdr_region_gate #(.REGIONS(REGIONS), .SEL_W(SEL_W)) u_gate (
      .sel      (req_region),
      .wr       (req_write),
      .lat_flat (cfg_lat),
      .wp       (cfg_wp),
      .valid    (cfg_valid),
      .ok       (acc_ok),
      .code     (acc_code)
   );

   assign acc_dly = lat_delays(acc_code);

   sdr_sched_calc #(.CNT_W(CNT_W)) u_sched (
      .dly   (acc_dly),
      .wr    (req_write),
      .t_cmd (s_cmd),
      .t_cap (s_cap),
      .t_pre (s_pre),
      .t_rdy (s_rdy)
   );

   assign accept = req_valid && ready_q;
   assign start  = accept && acc_ok;

   sdr_cmd_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .t_cmd   (s_cmd),
      .t_cap   (s_cap),
      .t_pre   (s_pre),
      .t_rdy   (s_rdy),
      .busy    (busy),
      .hit_cmd (hit_cmd),
      .hit_pre (hit_pre),
      .hit_cap (hit_cap),
      .hit_end (hit_end)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= CMD_NOP;
         addr_q  <= '0;
         oe_q    <= 1'b0;
         dq_q    <= '0;
         ready_q <= 1'b1;
         err_q   <= 1'b0;
         rv_q    <= 1'b0;
         rd_q    <= '0;
         wr_q    <= 1'b0;
         col_q   <= '0;
         wd_q    <= '0;
      end else begin
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
         oe_q   <= 1'b0;
         err_q  <= 1'b0;
         rv_q   <= 1'b0;
         if (accept) begin
            if (acc_ok) begin
               cmd_q   <= CMD_ACT;
               addr_q  <= ADDR_W'(req_row);
               ready_q <= 1'b0;
               wr_q    <= req_write;
               col_q   <= req_col;
               wd_q    <= req_wdata;
            end else begin
               err_q <= 1'b1;
            end
         end else if (busy) begin
            if (hit_cmd) begin
               cmd_q  <= wr_q ? CMD_WR : CMD_RD;
               addr_q <= ADDR_W'(col_q);
               oe_q   <= wr_q;
               dq_q   <= wd_q;
            end else if (hit_pre) begin
               cmd_q <= CMD_PRE;
            end
            if (hit_cap && !wr_q) begin
               rd_q <= sd_dq_in;
               rv_q <= 1'b1;
            end
            if (hit_end) ready_q <= 1'b1;
         end
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_addr   = addr_q;
   assign sd_dq_out = dq_q;
   assign sd_dq_oe  = oe_q;
   assign ready     = ready_q;
   assign err       = err_q;
   assign rd_valid  = rv_q;
   assign rd_data   = rd_q;

endmodule

// File: rtl/sdr_word_seq_chk.sv
`timescale 1ns/1ps
module sdr_word_seq_chk #(
   parameter int REGIONS = 2,
   parameter int SEL_W   = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_write,
   input logic [SEL_W-1:0]     req_region,
   input logic [2*REGIONS-1:0] cfg_lat,
   input logic [REGIONS-1:0]   cfg_wp,
   input logic [REGIONS-1:0]   cfg_valid,
   input logic                 ready,
   input logic                 err,
   input logic                 rd_valid,
   input logic                 sd_dq_oe,
   input logic                 sd_cs_n,
   input logic                 sd_ras_n,
   input logic                 sd_cas_n,
   input logic                 sd_we_n
);
   logic [3:0] cmd;
   logic       reg_ok;
   logic [1:0] reg_code;
   logic [3:0] rcd_now, rcd_q, rp_q, since_act, since_pre;
   int         idx;

   assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   always_comb begin
      idx      = int'(req_region);
      reg_ok   = 1'b0;
      reg_code = 2'd0;
      if (idx < REGIONS) begin
         reg_ok   = cfg_valid[idx] && !(req_write && cfg_wp[idx]);
         reg_code = cfg_lat[2*idx +: 2];
      end
      rcd_now = (reg_code == 2'd0) ? 4'd1 : (reg_code == 2'd1) ? 4'd2 : 4'd3;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rcd_q     <= 4'd1;
         rp_q      <= 4'd1;
         since_act <= 4'd15;
         since_pre <= 4'd15;
      end else begin
         if (req_valid && ready && reg_ok) rcd_q <= rcd_now;
         if (cmd == 4'b0011) since_act <= 4'd1;
         else if (since_act != 4'd15) since_act <= since_act + 4'd1;
         if (cmd == 4'b0010) begin
            since_pre <= 4'd1;
            rp_q      <= rcd_q;
         end else if (since_pre != 4'd15) since_pre <= since_pre + 4'd1;
      end
   end

   AST_ACCEPT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready && reg_ok) |=> (cmd == 4'b0011 && !ready)); // R2

   AST_COL_CMD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0101 || cmd == 4'b0100) |-> (since_act == rcd_q)); // R3

   AST_ROW_OPEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0010) |-> (since_act >= (rcd_q << 1))); // R4

   AST_RECOVERY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0011) |-> (since_pre >= rp_q)); // R8

   AST_OE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      sd_dq_oe |-> (cmd == 4'b0100)); // R6

   AST_READ_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R7

   AST_REFUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready && !reg_ok) |=> (err && ready && cmd == 4'b0111)); // R10

   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 4'b0011 || cmd == 4'b0101 || cmd == 4'b0100 ||
       cmd == 4'b0010 || cmd == 4'b0111)); // R12

endmodule

bind sdr_word_seq sdr_word_seq_chk #(.REGIONS(REGIONS), .SEL_W(SEL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_region (req_region),
   .cfg_lat    (cfg_lat),
   .cfg_wp     (cfg_wp),
   .cfg_valid  (cfg_valid),
   .ready      (ready),
   .err        (err),
   .rd_valid   (rd_valid),
   .sd_dq_oe   (sd_dq_oe),
   .sd_cs_n    (sd_cs_n),
   .sd_ras_n   (sd_ras_n),
   .sd_cas_n   (sd_cas_n),
   .sd_we_n    (sd_we_n)
);

// File: tb/sdr_word_seq_bench.sv
`timescale 1ns/1ps
module sdr_word_seq_bench;
   localparam int ROW_W = 13, COL_W = 10, DATA_W = 16, ADDR_W = 13;
   localparam logic [3:0] B_ACT = 4'b0011, B_RD = 4'b0101, B_WR = 4'b0100,
                          B_PRE = 4'b0010, B_NOP = 4'b0111;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_write = 1'b0;
   logic [0:0]        req_region = '0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [3:0]        cfg_lat = '0;
   logic [1:0]        cfg_wp = '0, cfg_valid = 2'b11;
   logic              ready, err, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
   logic [DATA_W-1:0] rd_data, sd_dq_out;
   logic [DATA_W-1:0] sd_dq_in = '0;
   logic [ADDR_W-1:0] sd_addr;

   always #2.5 clk = ~clk;

   sdr_word_seq u_sdr_word_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_region(req_region), .req_row(req_row), .req_col(req_col),
      .req_wdata(req_wdata), .cfg_lat(cfg_lat), .cfg_wp(cfg_wp),
      .cfg_valid(cfg_valid), .ready(ready), .err(err), .rd_valid(rd_valid),
      .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
      .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
      .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
   );

   int    checks = 0, failures = 0, cyc = 0;
   bit    finished = 0, cmp_en = 0;
   string tag = "R1";

   // reference model state
   bit                m_busy = 0, m_wr = 0;
   int                m_t, m_cmdt, m_cap, m_pre, m_rdy;
   logic [COL_W-1:0]  m_col;
   logic [DATA_W-1:0] m_wd;
   logic [3:0]        e_cmd = B_NOP;
   logic [ADDR_W-1:0] e_addr = '0;
   logic              e_ready = 1, e_err = 0, e_rv = 0, e_oe = 0;
   logic [DATA_W-1:0] e_rd = '0, e_dq = '0;

   task automatic chk(input bit good, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!good) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      int code, rcd, cl, ras, rp;
      bit ok;
      cyc++;
      if (!rst_n) begin
         m_busy = 0; e_ready = 1; e_cmd = B_NOP; e_addr = '0;
         e_err = 0; e_rv = 0; e_oe = 0;
      end else begin
         e_err = 0; e_rv = 0; e_oe = 0; e_cmd = B_NOP; e_addr = '0;
         if (!m_busy) begin
            if (req_valid) begin
               ok = cfg_valid[req_region] && !(req_write && cfg_wp[req_region]);
               if (ok) begin
                  code = int'(cfg_lat[2*req_region +: 2]);
                  rcd  = (code == 0) ? 1 : (code == 1) ? 2 : 3;
                  cl = rcd; ras = 2 * rcd; rp = rcd;
                  m_wr = req_write; m_col = req_col; m_wd = req_wdata;
                  m_t = 0; m_cmdt = rcd; m_cap = rcd + cl;
                  m_pre = m_wr ? rcd + 1 : rcd + cl + 1;
                  if (m_pre < ras) m_pre = ras;
                  m_rdy = m_pre + rp - 1;
                  m_busy = 1; e_ready = 0;
                  e_cmd = B_ACT; e_addr = ADDR_W'(req_row);
               end else e_err = 1;
            end
         end else begin
            if (m_t == m_cap && !m_wr) begin e_rd = sd_dq_in; e_rv = 1; end
            m_t++;
            if (m_t == m_cmdt) begin
               e_cmd = m_wr ? B_WR : B_RD; e_addr = ADDR_W'(m_col);
               e_oe = m_wr; e_dq = m_wd;
            end else if (m_t == m_pre) e_cmd = B_PRE;
            if (m_t == m_rdy) begin m_busy = 0; e_ready = 1; end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_en && !finished) begin
         logic [3:0] a_cmd;
         a_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
         chk(a_cmd === e_cmd, "R12 command", 32'(a_cmd), 32'(e_cmd));
         chk(ready === e_ready, "ready", 32'(ready), 32'(e_ready));
         chk(err === e_err, "err", 32'(err), 32'(e_err));
         chk(rd_valid === e_rv, "rd_valid", 32'(rd_valid), 32'(e_rv));
         chk(sd_dq_oe === e_oe, "dq_oe", 32'(sd_dq_oe), 32'(e_oe));
         chk(sd_addr === e_addr, "R12 address", 32'(sd_addr), 32'(e_addr));
         if (e_oe) chk(sd_dq_out === e_dq, "write data", 32'(sd_dq_out), 32'(e_dq));
         if (e_rv) chk(rd_data === e_rd, "read data", 32'(rd_data), 32'(e_rd));
      end
      sd_dq_in <= DATA_W'(cyc * 16'h2B + 16'h11);
   end

   task automatic issue(input logic rg, input logic wr, input int row, input int col,
                        input int wd);
      while (!ready) @(negedge clk);
      req_valid = 1; req_write = wr; req_region = rg;
      req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = DATA_W'(wd);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic settle();
      while (!ready) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1";
      chk(ready === 1'b1, "reset ready", 32'(ready), 1);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === B_NOP, "reset command",
          32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(B_NOP));
      chk(sd_dq_oe === 0 && err === 0 && rd_valid === 0, "reset strobes",
          32'({sd_dq_oe, err, rd_valid}), 0);
      rst_n = 1; cmp_en = 1;
      @(negedge clk);
      tag = "R1";
      chk(ready === 1'b1, "ready after reset", 32'(ready), 1);

      cfg_lat = {2'd1, 2'd0}; cfg_valid = 2'b11; cfg_wp = 2'b00;
      tag = "R3 R7"; issue(0, 0, 12'h155, 10'h03, 0); settle();
      tag = "R3 R6"; issue(0, 1, 12'h0AA, 10'h21, 16'hBEEF); settle();
      tag = "R4 R9 R7"; issue(1, 0, 12'h701, 10'h3F0, 0); settle();
      tag = "R4 R9 R6"; issue(1, 1, 12'h702, 10'h011, 16'h1234); settle();
      tag = "R2 R8";
      issue(0, 1, 1, 2, 16'hA5A5); issue(0, 0, 3, 4, 0);
      issue(1, 0, 5, 6, 0); issue(1, 1, 7, 8, 16'h5A5A); issue(0, 0, 9, 10, 0);
      settle();

      cfg_lat = {2'd3, 2'd2};
      tag = "R5";
      issue(0, 0, 100, 200, 0); settle();
      issue(1, 0, 101, 201, 0); settle();
      issue(0, 1, 102, 202, 16'hC0DE); settle();
      issue(1, 1, 103, 203, 16'hF00D); issue(1, 0, 104, 204, 0); settle();

      cfg_lat = {2'd0, 2'd1}; cfg_wp = 2'b10;
      tag = "R10";
      issue(1, 1, 50, 60, 16'hDEAD); settle();
      issue(1, 0, 51, 61, 0); settle();
      issue(0, 1, 52, 62, 16'h7777); settle();
      issue(1, 1, 53, 63, 16'h1111); issue(1, 1, 54, 64, 16'h2222); settle();

      cfg_wp = 2'b00; cfg_valid = 2'b01;
      tag = "R11";
      issue(1, 0, 70, 71, 0); settle();
      issue(1, 1, 72, 73, 16'h3333); issue(0, 0, 74, 75, 0); settle();

      cfg_valid = 2'b11; cfg_lat = {2'd1, 2'd2};
      tag = "R13";
      req_valid = 1; req_write = 0; req_region = 0;
      for (int i = 0; i < 40; i++) begin
         req_row = ROW_W'(i * 7 + 1); req_col = COL_W'(i * 3);
         req_write = i[2]; req_region = i[4]; req_wdata = DATA_W'(i * 99);
         @(negedge clk);
      end
      req_valid = 0;
      settle();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog expired tag=%s", tag);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule